// File: doc/BRIEF.md
# GPIO Bank with Programmable Pin Events

This block is a general-purpose I/O bank of up to 32 pins, controlled through a simple single-cycle register bus. Each pin has an output level register bit and a direction bit. A read-only register returns the synchronized pin levels. Software can change chosen output bits without a read-modify-write, using set, clear and toggle write aliases.

Every pin can flag an event when it sees one of four conditions: a low level, a high level, a rising edge or a falling edge. A separate per-pin bit changes the detection to both edges. Events latch into a sticky status register, which software clears by writing 1. A mask register decides which status bits reach the two combined interrupt lines, one for the lower half of the pins and one for the upper half.

Pin inputs go through a two-flop synchronizer before any detection. Edges are found by comparing the synchronized value with its value one cycle earlier. The bus read path is combinational: read data is valid in the same cycle as the address.

Top module: `gpio_event_bank`

## Requirements
- R1: After reset, the output data, direction, condition, mask and both-edge registers read 0, and pinOut, pinOutEn, irqLow and irqHigh are 0.
- R2: Writing the direction register at 0x04 sets pinOutEn to the written value on the next cycle (1 = output). pinOut always equals the output data register at 0x00.
- R3: A write to 0x84 sets, 0x88 clears and 0x8C inverts every output data bit written as 1. Bits written as 0 leave their data bit unchanged. Reads of these three addresses return 0.
- R4: The output data register keeps its value while a pin is an input, and the read of 0x00 returns the programmed level, not the pin level. pinOut changes only on a write to 0x00, 0x84, 0x88 or 0x8C.
- R5: The level register at 0x08 returns pinIn after the two-flop synchronizer. A pin change made between two clock edges becomes readable after the second rising edge that follows it.
- R6: Each pin has a 2-bit condition code: 0 = low level, 1 = high level, 2 = rising edge, 3 = falling edge. Pin i (i < 16) uses bits [2i+1:2i] of 0x0C. Pin i (i ≥ 16) uses bits [2(i-16)+1:2(i-16)] of 0x10. A level condition sets the pin's status bit on every cycle the level holds.
- R7: An edge condition sets the status bit once for each matching transition of the synchronized pin. After the status bit is cleared, it stays clear until the next matching transition.
- R8: When bit i of the both-edge register at 0x1C is 1, pin i detects rising and falling transitions, and its 2-bit condition code has no effect.
- R9: The status register at 0x18 is sticky. Writing 1 to a bit clears it, writing 0 leaves it, and a set bit stays set until it is cleared.
- R10: When a write-1-to-clear and a new detection hit the same status bit in the same cycle, the bit stays set.
- R11: irqLow is the OR of (status AND mask) over pins 0–15, and irqHigh is the OR over pins 16–31, using the mask register at 0x14. Status bits latch whether the pin is masked or not.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low asynchronous reset |
| busSel | input | 1 | Bus access in this cycle |
| busWrite | input | 1 | 1 = write, 0 = read |
| busAddr | input | ADDR_W | Byte address of the register |
| busWdata | input | NUM_PINS | Write data |
| busRdata | output | NUM_PINS | Read data, combinational, 0 when no read is in progress |
| pinIn | input | NUM_PINS | Asynchronous pin levels |
| pinOut | output | NUM_PINS | Output level for each pin |
| pinOutEn | output | NUM_PINS | Output enable for each pin |
| irqLow | output | 1 | Combined interrupt for pins 0–15 |
| irqHigh | output | 1 | Combined interrupt for pins 16–31 |

## Verification
The assertions check, on every cycle, the effect of bus writes seen at the ports. They cover the following:
- the direction write appearing on pinOutEn;
- the set, clear and toggle aliases acting on pinOut;
- pinOut holding steady when no data write occurs;
- both interrupt lines dropping after the mask is written with all zeros.

The condition decoding, the synchronizer latency, edge versus level behaviour, the both-edge override, sticky clearing and the same-cycle clear/detect conflict depend on pin stimulus sequences. Only the bench's scenarios show these, and it checks them through the status and level registers.

// File: rtl/gpio_event_pkg.sv
package gpio_event_pkg;

  localparam logic [7:0] OFS_DATA   = 8'h00;
  localparam logic [7:0] OFS_DIR    = 8'h04;
  localparam logic [7:0] OFS_LEVEL  = 8'h08;
  localparam logic [7:0] OFS_CONDLO = 8'h0C;
  localparam logic [7:0] OFS_CONDHI = 8'h10;
  localparam logic [7:0] OFS_MASK   = 8'h14;
  localparam logic [7:0] OFS_STATUS = 8'h18;
  localparam logic [7:0] OFS_BOTH   = 8'h1C;
  localparam logic [7:0] OFS_SET    = 8'h84;
  localparam logic [7:0] OFS_CLR    = 8'h88;
  localparam logic [7:0] OFS_TGL    = 8'h8C;

  typedef enum logic [1:0] {
    COND_LOW  = 2'd0,
    COND_HIGH = 2'd1,
    COND_RISE = 2'd2,
    COND_FALL = 2'd3
  } condCode_e;

  typedef enum logic [3:0] {
    RD_NONE, RD_DATA, RD_DIR, RD_LEVEL, RD_CONDLO,
    RD_CONDHI, RD_MASK, RD_STATUS, RD_BOTH
  } rdSel_e;

  // Strobes from the bus decoder to the register datapath
  typedef struct packed {
    logic   wrData;
    logic   wrSet;
    logic   wrClr;
    logic   wrTgl;
    logic   wrDir;
    logic   wrCondLo;
    logic   wrCondHi;
    logic   wrMask;
    logic   wrStatus;
    logic   wrBoth;
    rdSel_e rdSel;
  } regStrobe_t;

endpackage

// File: rtl/gpio_event_ctrl.sv
module gpio_event_ctrl
  import gpio_event_pkg::*;
#(
  parameter int unsigned ADDR_W = 8
) (
  input  logic              busSel,
  input  logic              busWrite,
  input  logic [ADDR_W-1:0] busAddr,
  output regStrobe_t        strobe
);

  logic wrEn;
  logic rdEn;

  assign wrEn = busSel & busWrite;
  assign rdEn = busSel & ~busWrite;

  always_comb begin
    strobe = '0;
    strobe.rdSel = RD_NONE;
    case (busAddr)
      ADDR_W'(OFS_DATA): begin
        strobe.wrData = wrEn;
        strobe.rdSel  = rdEn ? RD_DATA : RD_NONE;
      end
      ADDR_W'(OFS_DIR): begin
        strobe.wrDir = wrEn;
        strobe.rdSel = rdEn ? RD_DIR : RD_NONE;
      end
      ADDR_W'(OFS_LEVEL): begin
        strobe.rdSel = rdEn ? RD_LEVEL : RD_NONE;
      end
      ADDR_W'(OFS_CONDLO): begin
        strobe.wrCondLo = wrEn;
        strobe.rdSel    = rdEn ? RD_CONDLO : RD_NONE;
      end
      ADDR_W'(OFS_CONDHI): begin
        strobe.wrCondHi = wrEn;
        strobe.rdSel    = rdEn ? RD_CONDHI : RD_NONE;
      end
      ADDR_W'(OFS_MASK): begin
        strobe.wrMask = wrEn;
        strobe.rdSel  = rdEn ? RD_MASK : RD_NONE;
      end
      ADDR_W'(OFS_STATUS): begin
        strobe.wrStatus = wrEn;
        strobe.rdSel    = rdEn ? RD_STATUS : RD_NONE;
      end
      ADDR_W'(OFS_BOTH): begin
        strobe.wrBoth = wrEn;
        strobe.rdSel  = rdEn ? RD_BOTH : RD_NONE;
      end
      ADDR_W'(OFS_SET): strobe.wrSet = wrEn;
      ADDR_W'(OFS_CLR): strobe.wrClr = wrEn;
      ADDR_W'(OFS_TGL): strobe.wrTgl = wrEn;
      default: ;
    endcase
  end

endmodule

// File: rtl/gpio_event_dp.sv
module gpio_event_dp
  import gpio_event_pkg::*;
#(
  parameter int unsigned NUM_PINS = 32
) (
  input  logic                clk,
  input  logic                rstN,
  input  regStrobe_t          strobe,
  input  logic [NUM_PINS-1:0] busWdata,
  input  logic [NUM_PINS-1:0] pinIn,
  output logic [NUM_PINS-1:0] busRdata,
  output logic [NUM_PINS-1:0] pinOut,
  output logic [NUM_PINS-1:0] pinOutEn,
  output logic                irqLow,
  output logic                irqHigh
);

  localparam int unsigned HALF   = NUM_PINS / 2;
  localparam int unsigned COND_W = 2 * HALF;

  logic [NUM_PINS-1:0] dataQ, dirQ, maskQ, statusQ, bothQ;
  logic [COND_W-1:0]   condLoQ, condHiQ;
  logic [NUM_PINS-1:0] syncA, syncB, prevQ;
  logic [NUM_PINS-1:0] detect;
  logic [NUM_PINS-1:0] clearVec;

  // Two-flop synchronizer plus one history stage for edge detection
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      syncA <= '0;
      syncB <= '0;
      prevQ <= '0;
    end else begin
      syncA <= pinIn;
      syncB <= syncA;
      prevQ <= syncB;
    end
  end

  // Per-pin condition decode
  for (genvar i = 0; i < NUM_PINS; i++) begin : g_pin
    logic [1:0] code;
    logic       hit;
    if (i < HALF) begin : g_lo
      assign code = condLoQ[2*i +: 2];
    end else begin : g_hi
      assign code = condHiQ[2*(i-HALF) +: 2];
    end
    always_comb begin
      if (bothQ[i]) begin
        hit = syncB[i] ^ prevQ[i];
      end else begin
        case (condCode_e'(code))
          COND_LOW:  hit = ~syncB[i];
          COND_HIGH: hit = syncB[i];
          COND_RISE: hit = syncB[i] & ~prevQ[i];
          default:   hit = ~syncB[i] & prevQ[i];
        endcase
      end
    end
    assign detect[i] = hit;
  end

  assign clearVec = strobe.wrStatus ? busWdata : '0;

  // Configuration and output registers
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      dataQ   <= '0;
      dirQ    <= '0;
      maskQ   <= '0;
      bothQ   <= '0;
      condLoQ <= '0;
      condHiQ <= '0;
    end else begin
      if (strobe.wrData)      dataQ <= busWdata;
      else if (strobe.wrSet)  dataQ <= dataQ | busWdata;
      else if (strobe.wrClr)  dataQ <= dataQ & ~busWdata;
      else if (strobe.wrTgl)  dataQ <= dataQ ^ busWdata;
      if (strobe.wrDir)    dirQ    <= busWdata;
      if (strobe.wrMask)   maskQ   <= busWdata;
      if (strobe.wrBoth)   bothQ   <= busWdata;
      if (strobe.wrCondLo) condLoQ <= busWdata[COND_W-1:0];
      if (strobe.wrCondHi) condHiQ <= busWdata[COND_W-1:0];
    end
  end

  // Sticky status: detection wins over a same-cycle clear
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) statusQ <= '0;
    else       statusQ <= (statusQ & ~clearVec) | detect;
  end

  always_comb begin
    case (strobe.rdSel)
      RD_DATA:   busRdata = dataQ;
      RD_DIR:    busRdata = dirQ;
      RD_LEVEL:  busRdata = syncB;
      RD_CONDLO: busRdata = NUM_PINS'(condLoQ);
      RD_CONDHI: busRdata = NUM_PINS'(condHiQ);
      RD_MASK:   busRdata = maskQ;
      RD_STATUS: busRdata = statusQ;
      RD_BOTH:   busRdata = bothQ;
      default:   busRdata = '0;
    endcase
  end

  assign pinOut   = dataQ;
  assign pinOutEn = dirQ;
  assign irqLow   = |(statusQ[HALF-1:0] & maskQ[HALF-1:0]);
  assign irqHigh  = |(statusQ[NUM_PINS-1:HALF] & maskQ[NUM_PINS-1:HALF]);

endmodule

// File: rtl/gpio_event_bank.sv
module gpio_event_bank
  import gpio_event_pkg::*;
#(
  parameter int unsigned NUM_PINS = 32,
  parameter int unsigned ADDR_W   = 8
) (
  input  logic                clk,
  input  logic                rstN,
  input  logic                busSel,
  input  logic                busWrite,
  input  logic [ADDR_W-1:0]   busAddr,
  input  logic [NUM_PINS-1:0] busWdata,
  output logic [NUM_PINS-1:0] busRdata,
  input  logic [NUM_PINS-1:0] pinIn,
  output logic [NUM_PINS-1:0] pinOut,
  output logic [NUM_PINS-1:0] pinOutEn,
  output logic                irqLow,
  output logic                irqHigh
);

  regStrobe_t strobe;

  gpio_event_ctrl #(.ADDR_W(ADDR_W)) uCtrl (
    .busSel   (busSel),
    .busWrite (busWrite),
    .busAddr  (busAddr),
    .strobe   (strobe)
  );

  gpio_event_dp #(.NUM_PINS(NUM_PINS)) uDp (
    .clk      (clk),
    .rstN     (rstN),
    .strobe   (strobe),
    .busWdata (busWdata),
    .pinIn    (pinIn),
    .busRdata (busRdata),
    .pinOut   (pinOut),
    .pinOutEn (pinOutEn),
    .irqLow   (irqLow),
    .irqHigh  (irqHigh)
  );

endmodule

// File: rtl/gpio_event_chk.sv
module gpio_event_chk
  import gpio_event_pkg::*;
#(
  parameter int unsigned NUM_PINS = 32,
  parameter int unsigned ADDR_W   = 8
) (
  input logic                clk,
  input logic                rstN,
  input logic                busSel,
  input logic                busWrite,
  input logic [ADDR_W-1:0]   busAddr,
  input logic [NUM_PINS-1:0] busWdata,
  input logic [NUM_PINS-1:0] pinOut,
  input logic [NUM_PINS-1:0] pinOutEn,
  input logic                irqLow,
  input logic                irqHigh
);

  logic wrEn, wrDir, wrData, wrSet, wrClr, wrTgl, wrMask;

  assign wrEn   = busSel & busWrite;
  assign wrDir  = wrEn && (busAddr == ADDR_W'(OFS_DIR));
  assign wrData = wrEn && (busAddr == ADDR_W'(OFS_DATA));
  assign wrSet  = wrEn && (busAddr == ADDR_W'(OFS_SET));
  assign wrClr  = wrEn && (busAddr == ADDR_W'(OFS_CLR));
  assign wrTgl  = wrEn && (busAddr == ADDR_W'(OFS_TGL));
  assign wrMask = wrEn && (busAddr == ADDR_W'(OFS_MASK));

  // R2
  dir_follow_chk: assert property (@(posedge clk) disable iff (!rstN)
    wrDir |=> (pinOutEn == $past(busWdata)));

  // R3
  set_alias_chk: assert property (@(posedge clk) disable iff (!rstN)
    wrSet |=> (pinOut == ($past(pinOut) | $past(busWdata))));

  // R3
  clr_alias_chk: assert property (@(posedge clk) disable iff (!rstN)
    wrClr |=> (pinOut == ($past(pinOut) & ~$past(busWdata))));

  // R3
  tgl_alias_chk: assert property (@(posedge clk) disable iff (!rstN)
    wrTgl |=> (pinOut == ($past(pinOut) ^ $past(busWdata))));

  // R4
  data_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    !(wrData || wrSet || wrClr || wrTgl) |=> $stable(pinOut));

  // R11
  mask_off_chk: assert property (@(posedge clk) disable iff (!rstN)
    (wrMask && (busWdata == '0)) |=> (!irqLow && !irqHigh));

endmodule

bind gpio_event_bank gpio_event_chk #(.NUM_PINS(NUM_PINS), .ADDR_W(ADDR_W)) uChk (.*);

// File: tb/test_gpio_event_bank.sv
module test_gpio_event_bank;

  localparam int NP = 32;
  localparam int AW = 8;

  logic          clk;
  logic          rstN;
  logic          busSel;
  logic          busWrite;
  logic [AW-1:0] busAddr;
  logic [NP-1:0] busWdata;
  logic [NP-1:0] busRdata;
  logic [NP-1:0] pinIn;
  logic [NP-1:0] pinOut;
  logic [NP-1:0] pinOutEn;
  logic          irqLow;
  logic          irqHigh;

  int checks = 0;
  int fails  = 0;

  gpio_event_bank #(.NUM_PINS(NP), .ADDR_W(AW)) i_gpio_event_bank (
    .clk(clk), .rstN(rstN), .busSel(busSel), .busWrite(busWrite),
    .busAddr(busAddr), .busWdata(busWdata), .busRdata(busRdata),
    .pinIn(pinIn), .pinOut(pinOut), .pinOutEn(pinOutEn),
    .irqLow(irqLow), .irqHigh(irqHigh)
  );

  initial clk = 1'b0;
  always #4 clk = ~clk;

  task automatic check(input string tag, input logic [NP-1:0] got, input logic [NP-1:0] exp);
    checks++;
    if (got !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", tag, got, exp);
    end
  endtask

  task automatic busWr(input logic [7:0] a, input logic [NP-1:0] d);
    @(negedge clk);
    busSel = 1'b1; busWrite = 1'b1; busAddr = a; busWdata = d;
    @(negedge clk);
    busSel = 1'b0; busWrite = 1'b0;
  endtask

  // Combinational read at the current time; caller stands at a falling edge
  task automatic busRd(input logic [7:0] a, output logic [NP-1:0] d);
    busSel = 1'b1; busWrite = 1'b0; busAddr = a;
    #1;
    d = busRdata;
    busSel = 1'b0;
  endtask

  task automatic settle();
    repeat (5) @(negedge clk);
  endtask

  logic [NP-1:0] condLoM, condHiM;

  task automatic setCond(input int p, input logic [1:0] code);
    if (p < NP/2) begin
      condLoM[2*p +: 2] = code;
      busWr(8'h0C, condLoM);
    end else begin
      condHiM[2*(p-NP/2) +: 2] = code;
      busWr(8'h10, condHiM);
    end
  endtask

  function automatic logic [NP-1:0] bitOf(input int p);
    return NP'(1) << p;
  endfunction

  initial begin
    repeat (150000) @(posedge clk);
    checks++; fails++;
    $display("FAIL watchdog actual=timeout expected=finish");
    $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    logic [NP-1:0] rd, dataM, pat, m, c;
    int p;
    void'($urandom(32'd2024));
    rstN = 1'b0; busSel = 1'b0; busWrite = 1'b0; busAddr = '0; busWdata = '0;
    pinIn = '0; condLoM = '0; condHiM = '0;
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);

    // R1 reset state
    busRd(8'h00, rd); check("R1 data", rd, '0);
    busRd(8'h04, rd); check("R1 dir", rd, '0);
    busRd(8'h14, rd); check("R1 mask", rd, '0);
    busRd(8'h0C, rd); check("R1 condlo", rd, '0);
    busRd(8'h1C, rd); check("R1 both", rd, '0);
    check("R1 pinOutEn", pinOutEn, '0);
    check("R1 pinOut", pinOut, '0);
    check("R1 irq", {30'd0, irqHigh, irqLow}, '0);

    // R6 default code is low-level: all-low pins flag every bit
    settle();
    busRd(8'h18, rd); check("R6 default low level", rd, '1);

    // R2 direction
    m = $urandom;
    busWr(8'h04, m);
    check("R2 pinOutEn", pinOutEn, m);

    // R3 random data operations
    dataM = '0;
    for (int k = 0; k < 40; k++) begin
      int op;
      logic [NP-1:0] v;
      op = $urandom % 4;
      v = $urandom;
      case (op)
        0: begin busWr(8'h00, v); dataM = v; end
        1: begin busWr(8'h84, v); dataM = dataM | v; end
        2: begin busWr(8'h88, v); dataM = dataM & ~v; end
        default: begin busWr(8'h8C, v); dataM = dataM ^ v; end
      endcase
      busRd(8'h00, rd); check("R3 data readback", rd, dataM);
      check("R2 pinOut follows data", pinOut, dataM);
    end
    busWr(8'h84, '0);
    check("R3 zero set write", pinOut, dataM);
    busRd(8'h84, rd); check("R3 alias reads zero", rd, '0);
    busRd(8'h8C, rd); check("R3 toggle alias reads zero", rd, '0);

    // R4 retention while input
    busWr(8'h04, '0);
    dataM = 32'hA5C3_0F96;
    busWr(8'h00, dataM);
    pinIn = ~dataM;
    settle();
    busRd(8'h00, rd); check("R4 data not pins", rd, dataM);
    check("R4 pinOut retained", pinOut, dataM);
    check("R4 pinOutEn off", pinOutEn, '0);

    // R5 synchronizer latency
    pat = $urandom;
    pinIn = '0;
    settle();
    pinIn = pat;
    @(negedge clk);
    busRd(8'h08, rd); check("R5 level after one edge", rd, '0);
    @(negedge clk);
    busRd(8'h08, rd); check("R5 level after two edges", rd, pat);

    // Baseline: every pin high-level, pins low
    pinIn = '0;
    condLoM = 32'h5555_5555; condHiM = 32'h5555_5555;
    busWr(8'h0C, condLoM);
    busWr(8'h10, condHiM);
    settle();
    busWr(8'h18, '1);
    settle();
    busRd(8'h18, rd); check("R6 high level quiet", rd, '0);

    for (int t = 0; t < 2; t++) begin
      p = (t == 0) ? int'($urandom % 16) : 16 + int'($urandom % 16);
      // R7 rising
      setCond(p, 2'd2);
      busWr(8'h18, '1); settle();
      pinIn[p] = 1'b1; settle();
      busRd(8'h18, rd); check("R7 rising sets", rd, bitOf(p));
      busWr(8'h18, '1); settle();
      busRd(8'h18, rd); check("R7 rising once", rd, '0);
      // R7 falling
      setCond(p, 2'd3);
      busWr(8'h18, '1); settle();
      pinIn[p] = 1'b0; settle();
      busRd(8'h18, rd); check("R7 falling sets", rd, bitOf(p));
      busWr(8'h18, '1); settle();
      busRd(8'h18, rd); check("R7 falling once", rd, '0);
      // R10 same-cycle clear vs level detection
      setCond(p, 2'd0); settle();
      busWr(8'h18, '1);
      busRd(8'h18, rd); check("R10 detect beats clear", rd, bitOf(p));
      // R6 low level ends, high level starts
      pinIn[p] = 1'b1; settle();
      busWr(8'h18, '1); settle();
      busRd(8'h18, rd); check("R6 low level released", rd, '0);
      setCond(p, 2'd1); settle();
      busRd(8'h18, rd); check("R6 high level sets", rd, bitOf(p));
      // R8 both-edge override (code low, pin high)
      setCond(p, 2'd0);
      busWr(8'h1C, bitOf(p));
      busWr(8'h18, '1); settle();
      busRd(8'h18, rd); check("R8 override quiet high", rd, '0);
      pinIn[p] = 1'b0; settle();
      busRd(8'h18, rd); check("R8 falling edge", rd, bitOf(p));
      busWr(8'h18, '1); settle();
      busRd(8'h18, rd); check("R8 low level overridden", rd, '0);
      pinIn[p] = 1'b1; settle();
      busRd(8'h18, rd); check("R8 rising edge", rd, bitOf(p));
      // restore
      busWr(8'h1C, '0);
      setCond(p, 2'd1);
      pinIn[p] = 1'b0; settle();
      busWr(8'h18, '1); settle();
    end

    // R11 masking and combined lines
    for (int k = 0; k < 8; k++) begin
      pat = $urandom;
      pinIn = pat; settle();
      busWr(8'h18, '1); settle();
      busWr(8'h14, '0);
      busRd(8'h18, rd); check("R11 status latches while masked", rd, pat);
      check("R11 irq masked", {30'd0, irqHigh, irqLow}, '0);
      m = (k == 0) ? 32'h0000_FFFF : (k == 1) ? 32'hFFFF_0000 : $urandom;
      busWr(8'h14, m);
      #1;
      check("R11 irqLow", {31'd0, irqLow}, {31'd0, |(pat[15:0] & m[15:0])});
      check("R11 irqHigh", {31'd0, irqHigh}, {31'd0, |(pat[31:16] & m[31:16])});
      if (k == 0) begin
        busWr(8'h18, '0);
        busRd(8'h18, rd); check("R9 zero write keeps status", rd, pat);
      end
    end
    busWr(8'h14, '0);

    // R9 sticky with partial clear, rising on all pins
    pinIn = '0;
    busWr(8'h0C, 32'hAAAA_AAAA);
    busWr(8'h10, 32'hAAAA_AAAA);
    settle();
    busWr(8'h18, '1); settle();
    pat = $urandom;
    pinIn = pat; settle();
    pinIn = '0; settle();
    busRd(8'h18, rd); check("R9 sticky after pulse", rd, pat);
    c = $urandom;
    busWr(8'h18, c); settle();
    busRd(8'h18, rd); check("R9 partial clear", rd, pat & ~c);

    $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

endmodule